// File: doc/BRIEF.md
# Register-Mapped Stream Push Bridge

This block sits on a simple register-access bus as a slave and lets a processor feed 32-bit words into a one-way, point-to-point stream link. Each word that leaves the bridge travels with a one-bit side flag that tells the receiver whether the word is control information or ordinary payload. One bridge drives exactly one outgoing link. A system that needs several links places several bridges next to each other on the same bus.

Software pushes a word by writing it to the data register. The bridge answers each accepted write with a single one-clock write strobe on its stream port, with the word and its flag held in registers. The bus never stalls. Back-pressure from the link shows up instead as a live "full" bit in a status register. A push attempted while the link is full is dropped and leaves a sticky overflow mark. To tag a word as control, software arms a one-shot enable beforehand. The enable applies to the next word that is accepted and then disarms itself.

Top module: `bus2stream_bridge`

## Requirements
- R1: After reset the stream write strobe is low, the status register reads 0 while the link is not full, and the control-enable register reads 0.
- R2: A bus write to byte offset 0x0 while `st_full` is low makes `st_wr` high for exactly the following clock cycle. In that cycle `st_data` equals the written word.
- R3: A bus write to offset 0x0 while `st_full` is high produces no strobe and sets status bit 1, the overflow flag.
- R4: The overflow flag stays set until a bus write to offset 0x4 with bit 1 set clears it. Writing 0 to bit 1 leaves it set.
- R5: Writing 1 to bit 0 of offset 0x8 arms control-enable. The next accepted word leaves with `st_ctrl` high, and the enable then reads 0 again. The word after that leaves with `st_ctrl` low.
- R6: A rejected write (link full) does not consume an armed control-enable. It still reads 1 afterwards.
- R7: Status bit 0 read at offset 0x4 reflects `st_full` in the same cycle.
- R8: Offset 0x0 reads as zero. Writes to offsets 0x4, 0x8 or any unmapped offset produce no stream strobe.
- R9: Writes to offset 0x0 on consecutive cycles, with the link not full, produce strobes on consecutive cycles, in order and with no word lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write request, one cycle per access |
| bus_rd_en | input | 1 | Register read request |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| st_data | output | 32 | Stream word |
| st_ctrl | output | 1 | Stream control flag for the word |
| st_wr | output | 1 | Stream write strobe |
| st_full | input | 1 | Stream link cannot take a word |

## Verification
The assertions assume at most one register access per cycle, with `bus_wr_en` and `bus_rd_en` never both high. They also assume that `st_full` is only a level sampled at the clock edge, so any value may appear in any cycle. The stimulus issues one access per cycle from a single driver task and changes `st_full` only between accesses, away from the clock edge. It uses byte-aligned offsets and one deliberately unmapped offset.

// File: rtl/b2s_pkg.sv
package b2s_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              ctrl;
        logic              wr;
        logic              ovf;
        logic              cen;
    } state_t;

endpackage

// File: rtl/b2s_decode.sv
module b2s_decode
    import b2s_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             misaligned;

    assign idx        = addr[ADDR_W-1:2];
    assign misaligned = |addr[1:0];

    always_comb begin
        sel = SEL_NONE;
        if (!misaligned) begin
            if (idx == IDX_W'(0))      sel = SEL_DATA;
            else if (idx == IDX_W'(1)) sel = SEL_STAT;
            else if (idx == IDX_W'(2)) sel = SEL_CTRL;
            else                       sel = SEL_NONE;
        end
    end
endmodule

// File: rtl/b2s_rdmux.sv
module b2s_rdmux
    import b2s_pkg::*;
(
    input  logic              rd_en,
    input  sel_e              sel,
    input  logic              full,
    input  logic              ovf,
    input  logic              cen,
    output logic [WORD_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (sel)
                SEL_STAT: rdata = {{(WORD_W-2){1'b0}}, ovf, full};
                SEL_CTRL: rdata = {{(WORD_W-1){1'b0}}, cen};
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/bus2stream_bridge.sv
module bus2stream_bridge
    import b2s_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [31:0]       st_data,
    output logic              st_ctrl,
    output logic              st_wr,
    input  logic              st_full
);
    localparam int OVF_BIT = 1;
    localparam int CEN_BIT = 0;

    state_t cur_q, nxt_d;
    sel_e   sel;
    logic   wr_data, wr_stat, wr_ctrl;
    logic   push, reject;
    logic   ovf_q, cen_q;

    b2s_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign wr_data = bus_wr_en && (sel == SEL_DATA);
    assign wr_stat = bus_wr_en && (sel == SEL_STAT);
    assign wr_ctrl = bus_wr_en && (sel == SEL_CTRL);
    assign push    = wr_data && !st_full;
    assign reject  = wr_data &&  st_full;

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.wr = 1'b0;
        if (push) begin
            nxt_d.wr   = 1'b1;
            nxt_d.data = bus_wdata;
            nxt_d.ctrl = cur_q.cen;
            nxt_d.cen  = 1'b0;
        end
        if (reject) begin
            nxt_d.ovf = 1'b1;
        end
        if (wr_stat && bus_wdata[OVF_BIT]) begin
            nxt_d.ovf = 1'b0;
        end
        if (wr_ctrl) begin
            nxt_d.cen = bus_wdata[CEN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign ovf_q   = cur_q.ovf;
    assign cen_q   = cur_q.cen;
    assign st_data = cur_q.data;
    assign st_ctrl = cur_q.ctrl;
    assign st_wr   = cur_q.wr;

    b2s_rdmux u_rdmux (
        .rd_en (bus_rd_en),
        .sel   (sel),
        .full  (st_full),
        .ovf   (ovf_q),
        .cen   (cen_q),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/b2s_checker.sv
module b2s_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              st_full,
    input logic              st_wr,
    input logic [31:0]       st_data,
    input logic              st_ctrl,
    input logic              ovf_q,
    input logic              cen_q
);
    logic wr_d, wr_s;
    assign wr_d = bus_wr_en && (bus_addr == ADDR_W'(0));
    assign wr_s = bus_wr_en && (bus_addr == ADDR_W'(4));

    AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |-> $past(wr_d && !st_full)); // R2

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_d && !st_full) |=> (st_wr && st_data == $past(bus_wdata))); // R2

    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_d && st_full) |=> (!st_wr && ovf_q)); // R3

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(wr_s && bus_wdata[1])) |=> ovf_q); // R4

    AST_CTRL_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |-> (st_ctrl == $past(cen_q) && !cen_q)); // R5

    AST_CEN_KEPT_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_d && st_full && cen_q) |=> cen_q); // R6
endmodule

bind bus2stream_bridge b2s_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .st_full   (st_full),
    .st_wr     (st_wr),
    .st_data   (st_data),
    .st_ctrl   (st_ctrl),
    .ovf_q     (ovf_q),
    .cen_q     (cen_q)
);

// File: tb/bus2stream_bridge_bench.sv
module bus2stream_bridge_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr_en = 1'b0;
    logic              bus_rd_en = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [31:0]       st_data;
    logic              st_ctrl;
    logic              st_wr;
    logic              st_full = 1'b0;

    int checks = 0;
    int fails  = 0;
    int pushes = 0;
    int seen   = 0;
    bit done   = 0;
    logic [32:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bus2stream_bridge #(.ADDR_W(ADDR_W)) u_bus2stream_bridge (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .st_data(st_data), .st_ctrl(st_ctrl), .st_wr(st_wr), .st_full(st_full)
    );

    task automatic check(input bit ok, input string req, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // driver: called at a negedge, returns at the next negedge
    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input bit cen);
        if (a == 0 && !st_full) begin
            exp_q.push_back({cen, d});
            pushes++;
        end
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_rd_en = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd_en = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && st_wr) begin
            seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected strobe", {st_ctrl, st_data}, 33'h0);
            end else begin
                logic [32:0] e;
                e = exp_q.pop_front();
                check({st_ctrl, st_data} === e, "R2/R5/R9 stream word", {st_ctrl, st_data}, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(st_wr == 1'b0, "R1 strobe low", 33'(st_wr), 33'h0);
        bus_rd(4'h4, r); check(r == 0, "R1 status", 33'(r), 33'h0);
        bus_rd(4'h8, r); check(r == 0, "R1 cen", 33'(r), 33'h0);

        // R2, R9: back-to-back pushes
        bus_wr(4'h0, 32'hDEAD_BEEF, 1'b0);
        bus_wr(4'h0, 32'h1234_5678, 1'b0);
        bus_wr(4'h0, 32'h0000_0001, 1'b0);
        @(negedge clk);

        // R7
        st_full = 1'b1;
        bus_rd(4'h4, r); check(r[0] == 1'b1, "R7 full visible", 33'(r), 33'h1);
        // R3
        bus_wr(4'h0, 32'hBAD0_BAD0, 1'b0);
        @(negedge clk);
        bus_rd(4'h4, r); check(r == 32'h3, "R3 overflow set", 33'(r), 33'h3);
        // R6
        bus_wr(4'h8, 32'h1, 1'b0);
        bus_wr(4'h0, 32'hBAD1_BAD1, 1'b0);
        bus_rd(4'h8, r); check(r == 32'h1, "R6 cen kept", 33'(r), 33'h1);
        st_full = 1'b0;
        bus_rd(4'h4, r); check(r == 32'h2, "R7 full cleared", 33'(r), 33'h2);
        // R5
        bus_wr(4'h0, 32'hC0DE_0001, 1'b1);
        bus_rd(4'h8, r); check(r == 0, "R5 cen auto-clear", 33'(r), 33'h0);
        bus_wr(4'h0, 32'hC0DE_0002, 1'b0);
        @(negedge clk);
        // R4
        bus_wr(4'h4, 32'h0, 1'b0);
        bus_rd(4'h4, r); check(r == 32'h2, "R4 sticky on write 0", 33'(r), 33'h2);
        bus_wr(4'h4, 32'h2, 1'b0);
        bus_rd(4'h4, r); check(r == 0, "R4 cleared by W1C", 33'(r), 33'h0);
        // R8
        bus_rd(4'h0, r); check(r == 0, "R8 data reads zero", 33'(r), 33'h0);
        bus_wr(4'h8, 32'h0, 1'b0);
        bus_wr(4'hC, 32'hFFFF_FFFF, 1'b0);
        bus_wr(4'h4, 32'h1, 1'b0);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2 all words delivered", 33'(exp_q.size()), 33'h0);
        check(seen == pushes, "R9 strobe count", 33'(seen), 33'(pushes));

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule